// File: doc/BRIEF.md
# Thermal Shutdown Restart Controller

This block sequences the enable of a switched field-supply output that carries thermal overload protection. Two comparator flags come in from analog circuitry: one reports that the die has passed the trip temperature, the other that it has cooled below a lower re-arm temperature. The controller cuts the supply as soon as the trip flag is seen. It waits for the re-arm flag, then lets a fixed hold-off time run out before it switches the supply back on. The hold-off is `HOLD_CYCLES` clocks, about one second at a 5.333333 MHz clock by default. The bench sets it to a short value.

A sticky fault flag records every trip until software-side logic pulses a clear input. A transmit-inhibit output stops data transmission while the field supply is reported low or is switched off. All comparator flags pass through a synchronizer of `SYNC_STAGES` flops before use.

The state machine has four states:
- SETTLE: entered on reset. The supply is off while the synchronizer fills.
- ON: the supply is enabled.
- TRIPPED: the supply is off and the controller waits for re-arm.
- HOLDOFF: the supply is off and the delay is counting.

It has six transitions:
- SETTLE to ON, when the settle count is complete and the trip flag is clear.
- SETTLE to TRIPPED, when the settle count is complete and the trip flag is set.
- ON to TRIPPED, on the trip flag.
- TRIPPED to HOLDOFF, when the re-arm flag is set and the trip flag is clear.
- HOLDOFF to TRIPPED, on the trip flag. The delay is cancelled.
- HOLDOFF to ON, when the delay expires.

Top module: `thermal_restart_ctrl`

## Requirements
- R1: A trip flag driven high before clock edge a turns `supply_en_o` off after edge a+2 (two synchronizer flops plus the state register). It is still on after edge a+1.
- R2: After a trip, the supply stays off while the re-arm flag is low, even when the trip flag has gone low.
- R3: With the trip flag low, a re-arm flag driven high before edge a enters HOLDOFF at edge a+2. The supply turns on at edge a+2+HOLD_CYCLES and not earlier.
- R4: A trip flag seen during HOLDOFF returns the controller to TRIPPED and discards the elapsed delay. A later re-arm starts the full HOLD_CYCLES again.
- R5: Following reset the supply is off for SYNC_STAGES+1 edges. The controller then enters ON if the synchronized trip flag is low, or TRIPPED if it is high. A trip seen in SETTLE also sets the fault flag.
- R6: `fault_o` is 0 after reset. It is set at the edge where the controller enters TRIPPED from any other state, and it holds until an edge with `fault_clr_i` high clears it. A trip event in the same cycle as a clear leaves the flag set.
- R7: `fault_clr_i` has no effect on `supply_en_o`.
- R8: `tx_inhibit_o` is 1 whenever `supply_en_o` is 0. It is also 1 whenever the synchronized low-supply flag is 1. A low-supply flag driven before edge a takes effect after edge a+1.
- R9: A re-arm flag that arrives while the trip flag is still high is ignored. Restart waits until the trip flag clears.
- R10: The re-arm flag falling during HOLDOFF does not cancel the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| over_temp_i | input | 1 | Comparator flag: die above trip threshold |
| below_rearm_i | input | 1 | Comparator flag: die below re-arm threshold |
| supply_low_i | input | 1 | Flag: field supply voltage below transmit limit |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| supply_en_o | output | 1 | Field-supply enable |
| fault_o | output | 1 | Sticky over-temperature fault flag |
| tx_inhibit_o | output | 1 | Blocks data transmission when high |

## Verification
The embedded properties check the following on every cycle:
- A synchronized trip always moves ON to TRIPPED on the next edge.
- The supply can only come on from HOLDOFF or SETTLE.
- HOLDOFF cannot exit to ON before the delay counter reports completion.
- The counter never exceeds its limit.
- The fault flag stays set until cleared.

Only the bench scenarios can show the exact latencies, because they depend on the pipeline through the synchronizer:
- the cycle-accurate hold-off length;
- the full restart after a trip cancels HOLDOFF;
- the reset-time decision with the trip flag already high;
- the re-arm flag being ignored while trip is high.

// File: rtl/thr_pkg.sv
package thr_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE   = 2'd0,
        ST_ON       = 2'd1,
        ST_TRIPPED  = 2'd2,
        ST_HOLDOFF  = 2'd3
    } thr_state_e;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
    parameter int HOLD_CYCLES = 5333333
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done_o = run_i && (cnt == LAST);

    // R3: the count never passes its limit
    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < HOLD_CYCLES);
endmodule

// File: rtl/thr_fsm.sv
module thr_fsm
    import thr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trip_s,
    input  logic rearm_s,
    input  logic hold_done,
    input  logic fault_clr,
    output logic hold_run,
    output logic supply_en,
    output logic fault
);
    localparam int SW = $clog2(SYNC_STAGES + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SYNC_STAGES);

    thr_state_e state, state_nx;
    logic [SW-1:0] settle_cnt;
    logic trip_event;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SETTLE:  if (settle_cnt == SETTLE_LAST)
                            state_nx = trip_s ? ST_TRIPPED : ST_ON;
            ST_ON:      if (trip_s) state_nx = ST_TRIPPED;
            ST_TRIPPED: if (!trip_s && rearm_s) state_nx = ST_HOLDOFF;
            ST_HOLDOFF: if (trip_s) state_nx = ST_TRIPPED;
                        else if (hold_done) state_nx = ST_ON;
            default:    state_nx = ST_SETTLE;
        endcase
    end

    assign trip_event = (state_nx == ST_TRIPPED) && (state != ST_TRIPPED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_SETTLE;
            settle_cnt <= '0;
            fault      <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_SETTLE && settle_cnt != SETTLE_LAST)
                settle_cnt <= settle_cnt + 1'b1;
            fault <= (fault && !fault_clr) || trip_event;
        end
    end

    always_comb begin
        supply_en = 1'b0;
        hold_run  = 1'b0;
        unique case (state)
            ST_SETTLE:  ;
            ST_ON:      supply_en = 1'b1;
            ST_TRIPPED: ;
            ST_HOLDOFF: hold_run = 1'b1;
            default:    ;
        endcase
    end

    // R1: a synchronized trip always ends ON on the next edge
    assert_trip_off_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && trip_s) |=> (state == ST_TRIPPED));

    // R2: the supply only comes on from HOLDOFF or SETTLE
    assert_restart_path_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ON && $past(state) != ST_ON) |->
            ($past(state) == ST_HOLDOFF || $past(state) == ST_SETTLE));

    // R3: no exit to ON before the timer reports completion
    assert_no_early_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLDOFF && !hold_done) |=> (state != ST_ON));

    // R6: the fault flag is sticky until cleared
    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (fault && !fault_clr) |=> fault);
endmodule

// File: rtl/thermal_restart_ctrl.sv
module thermal_restart_ctrl #(
    parameter int HOLD_CYCLES = 5333333,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic over_temp_i,
    input  logic below_rearm_i,
    input  logic supply_low_i,
    input  logic fault_clr_i,
    output logic supply_en_o,
    output logic fault_o,
    output logic tx_inhibit_o
);
    localparam int NFLAGS = 3;

    logic [NFLAGS-1:0] flags_s;
    logic hold_run, hold_done, supply_en;

    flag_sync #(.WIDTH(NFLAGS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({supply_low_i, below_rearm_i, over_temp_i}),
        .sync_o  (flags_s)
    );

    holdoff_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (hold_run),
        .done_o (hold_done)
    );

    thr_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trip_s    (flags_s[0]),
        .rearm_s   (flags_s[1]),
        .hold_done (hold_done),
        .fault_clr (fault_clr_i),
        .hold_run  (hold_run),
        .supply_en (supply_en),
        .fault     (fault_o)
    );

    assign supply_en_o  = supply_en;
    assign tx_inhibit_o = !supply_en || flags_s[2];
endmodule

// File: tb/thermal_restart_ctrl_tb.sv
module thermal_restart_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst, ot, br, lo, clr;
    logic en, flt, inh;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_restart_ctrl #(.HOLD_CYCLES(N), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .over_temp_i(ot), .below_rearm_i(br),
        .supply_low_i(lo), .fault_clr_i(clr),
        .supply_en_o(en), .fault_o(flt), .tx_inhibit_o(inh)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    // expected-value model built from the requirement latencies
    int   m_state;
    int   m_cnt, m_set;
    logic m_fault;
    logic p1_ot, p2_ot, p1_br, p2_br, p1_lo, p2_lo;

    function automatic logic exp_inh(input int st, input logic low_s);
        return (st != 1) || low_s;
    endfunction

    task automatic model_reset();
        m_state = 0; m_cnt = 0; m_set = 0; m_fault = 1'b0;
        p1_ot = 0; p2_ot = 0; p1_br = 0; p2_br = 0; p1_lo = 0; p2_lo = 0;
    endtask

    task automatic model_edge(input logic c);
        int nx;
        nx = m_state;
        case (m_state)
            0: if (m_set == 2) nx = p2_ot ? 2 : 1;
            1: if (p2_ot) nx = 2;
            2: if (!p2_ot && p2_br) nx = 3;
            3: if (p2_ot) nx = 2; else if (m_cnt == N-1) nx = 1;
            default: nx = 0;
        endcase
        m_fault = (m_fault && !c) || (nx == 2 && m_state != 2);
        if (m_state == 0 && m_set != 2) m_set++;
        if (m_state == 3 && nx == 3) m_cnt++; else m_cnt = 0;
        m_state = nx;
        p2_ot = p1_ot; p2_br = p1_br; p2_lo = p1_lo;
        p1_ot = ot; p1_br = br; p1_lo = lo;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        ot = 0; br = 0; lo = 0; clr = 0; rst = 1;
        @(negedge clk);
        // R5 / R6 reset state
        do_reset();
        chk("R6", "fault after reset", flt, 1'b0);
        chk("R8", "inhibit while off", inh, 1'b1);
        step(2);
        chk("R5", "off during settle", en, 1'b0);
        step(1);
        chk("R5", "on after settle", en, 1'b1);
        chk("R8", "inhibit released", inh, 1'b0);

        // R1 trip latency
        ot = 1; step(2);
        chk("R1", "still on after a+1", en, 1'b1);
        step(1);
        chk("R1", "off after a+2", en, 1'b0);
        chk("R6", "fault set", flt, 1'b1);
        chk("R8", "inhibit when off", inh, 1'b1);

        // R2 no restart without re-arm
        ot = 0; step(30);
        chk("R2", "stays off", en, 1'b0);

        // R6 / R7 clear
        clr = 1; step(1); clr = 0;
        chk("R6", "fault cleared", flt, 1'b0);
        chk("R7", "clear leaves supply", en, 1'b0);

        // R3 exact hold-off
        br = 1; step(N+2);
        chk("R3", "off just before delay end", en, 1'b0);
        step(1);
        chk("R3", "on at delay end", en, 1'b1);

        // R10 re-arm falling during hold-off
        br = 0; ot = 1; step(3);
        chk("R1", "second trip", en, 1'b0);
        ot = 0; br = 1; step(5); br = 0; step(N-3);
        chk("R10", "off before delay end", en, 1'b0);
        step(1);
        chk("R10", "on despite re-arm loss", en, 1'b1);

        // R4 trip during hold-off restarts delay
        clr = 1; ot = 1; step(1); clr = 0; step(2);
        chk("R6", "trip beats clear", flt, 1'b1);
        ot = 0; br = 1; step(10);
        ot = 1; step(1); ot = 0;
        step(N+2);
        chk("R4", "cancelled hold-off", en, 1'b0);
        step(1);
        chk("R4", "full delay then on", en, 1'b1);

        // R9 re-arm ignored while trip high
        ot = 1; br = 1; step(3);
        chk("R9", "off with both flags", en, 1'b0);
        step(N+5);
        chk("R9", "re-arm ignored", en, 1'b0);
        ot = 0; step(N+2);
        chk("R9", "off before delay end", en, 1'b0);
        step(1);
        chk("R9", "on after trip clears", en, 1'b1);

        // R8 low-supply latency
        lo = 1; step(1);
        chk("R8", "low after a", inh, 1'b0);
        step(1);
        chk("R8", "low after a+1", inh, 1'b1);
        lo = 0; step(1);
        chk("R8", "release after a", inh, 1'b1);
        step(1);
        chk("R8", "release after a+1", inh, 1'b0);

        // R5 reset with trip already high
        ot = 1; br = 0; clr = 1; step(1); clr = 0;
        do_reset();
        step(3);
        chk("R5", "tripped after settle", en, 1'b0);
        chk("R5", "fault on reset trip", flt, 1'b1);
        step(10);
        chk("R5", "remains off", en, 1'b0);
        ot = 0; br = 1; step(N+2);
        chk("R5", "off before delay end", en, 1'b0);
        step(1);
        chk("R5", "on after delay", en, 1'b1);

        // random phase against the model
        ot = 0; br = 0; lo = 0; clr = 0;
        rst = 1; step(2);
        rst = 0;
        model_reset();
        for (int cyc = 0; cyc < 3000; cyc++) begin
            ot  = ($urandom % 40) == 0 ? ~ot : ot;
            br  = ($urandom % 6) == 0 ? ~br : br;
            lo  = ($urandom % 10) == 0 ? ~lo : lo;
            clr = ($urandom % 25) == 0;
            @(posedge clk);
            model_edge(clr);
            @(negedge clk);
            chk("R3", "random supply_en", en, logic'(m_state == 1));
            chk("R6", "random fault", flt, m_fault);
            chk("R8", "random inhibit", inh, exp_inh(m_state, p2_lo));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule